// File: doc/BRIEF.md
# Adaptive thermal throttling controller

This block lowers a core's frequency ratio in single steps while a digital temperature reading reports zero margin to a fixed trip point. Each step gates the core clock for a bounded window and changes the ratio while the clock is gated. It then restarts the clock and asks the voltage regulator to lower the supply. After the regulator confirms, the block waits a fixed re-check interval before it looks at the temperature again.

If the margin is still zero once the configured floor ratio has been reached, the block turns on clock modulation at that floor. When the margin becomes non-zero again, modulation and the hot indication drop at once. The ratio then climbs back one step per re-check interval until it reaches the nominal maximum, and the block returns to idle.

The only thing that starts throttling is the sensor's margin reading. Neither software nor an external pin can trigger it. The sensor, the clock generator and the regulator are outside the block: the clock generator is represented by the gated clock enable, and the regulator by a request and settle handshake.

Top module: `thr_throttle_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, the ratio equals `ratio_max`, `core_clk_en` is 1, and `vr_down_req`, `clk_mod_en` and `hot_out` are 0. Reset is synchronous and active low.
- R2: A `temp_margin` value of zero (all bits 0) starts a throttling step at the next clock edge. A non-zero margin while idle never gates the clock and never changes the ratio.
- R3: `hot_out` is 1 exactly one cycle after a zero margin is sampled, and only when `hot_bidir_en` is 1. It returns to 0 one cycle after the margin becomes non-zero.
- R4: A step holds `core_clk_en` at 0 for exactly `STOP_CYCLES` cycles. The ratio changes by exactly one, and only on the edge that gates the clock.
- R5: After a downward step the clock runs again and `vr_down_req` stays 1 until `vr_settled` is sampled high. The request then drops on the next cycle.
- R6: After the regulator settles, the block waits `RECHECK_CYCLES` cycles with the clock running. If the margin is still zero at the end of that wait, it takes another downward step.
- R7: The ratio never falls below `ratio_min`.
- R8: A zero margin at a re-check, or at activation, with the ratio already at `ratio_min` sets `clk_mod_en` with the clock running and the ratio unchanged. `clk_mod_en` clears one cycle after the margin becomes non-zero.
- R9: Once the margin is non-zero, the ratio rises by one step (a gated window of `STOP_CYCLES` cycles with no voltage request) per re-check interval. Consecutive rises are `STOP_CYCLES + RECHECK_CYCLES` cycles apart, and the ratio stops at `ratio_max`.
- R10: The gated window is checked when the design is elaborated and fits within 2 µs of the clock: `STOP_CYCLES <= 2 * CLK_MHZ`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| temp_margin | input | MARGIN_W | Distance to the trip point; zero means tripped |
| ratio_min | input | RATIO_W | Lowest ratio throttling may reach |
| ratio_max | input | RATIO_W | Nominal ratio restored after cooling |
| hot_bidir_en | input | 1 | Hot pin configured as driven output |
| vr_settled | input | 1 | Regulator has reached the lower voltage |
| core_clk_en | output | 1 | Core clock enable; 0 during a step |
| cur_ratio | output | RATIO_W | Current frequency ratio |
| vr_down_req | output | 1 | Request for a lower core voltage |
| hot_out | output | 1 | Hot indication |
| clk_mod_en | output | 1 | Clock duty-cycle modulation enable |

## Verification
The assertions assume that `ratio_min` is no greater than `ratio_max`. They also assume that both configuration inputs hold steady while the ratio is away from idle, so that the floor check and the single-step check refer to fixed bounds. The stimulus changes `ratio_min` only while the controller sits idle at `ratio_max`, and it never moves `ratio_max`. `vr_settled` is raised only while a request is pending, for a single cycle. This comes either from an explicit pulse or from a responder that answers one cycle after the request appears.

// File: rtl/thr_pkg.sv
package thr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STOP,
        ST_VREQ,
        ST_WAIT,
        ST_MOD
    } thr_state_e;

endpackage

// File: rtl/thr_cycle_timer.sv
module thr_cycle_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/thr_ratio_stepper.sv
module thr_ratio_stepper #(
    parameter int RATIO_W = 6
) (
    input  logic [RATIO_W-1:0] cur,
    input  logic [RATIO_W-1:0] lo,
    input  logic [RATIO_W-1:0] hi,
    output logic [RATIO_W-1:0] dn,
    output logic [RATIO_W-1:0] up,
    output logic               can_dn,
    output logic               can_up
);
    always_comb begin
        can_dn = (cur > lo);
        can_up = (cur < hi);
        dn     = cur - RATIO_W'(1);
        up     = cur + RATIO_W'(1);
    end
endmodule

// File: rtl/thr_throttle_ctrl.sv
module thr_throttle_ctrl #(
    parameter int RATIO_W        = 6,
    parameter int MARGIN_W       = 8,
    parameter int CLK_MHZ        = 200,
    parameter int STOP_CYCLES    = 400,
    parameter int RECHECK_CYCLES = 200000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [MARGIN_W-1:0] temp_margin,
    input  logic [RATIO_W-1:0]  ratio_min,
    input  logic [RATIO_W-1:0]  ratio_max,
    input  logic                hot_bidir_en,
    input  logic                vr_settled,
    output logic                core_clk_en,
    output logic [RATIO_W-1:0]  cur_ratio,
    output logic                vr_down_req,
    output logic                hot_out,
    output logic                clk_mod_en
);
    import thr_pkg::*;

    localparam int STOP_BUDGET = 2 * CLK_MHZ;
    localparam int MAX_CNT     = (STOP_CYCLES > RECHECK_CYCLES) ? STOP_CYCLES : RECHECK_CYCLES;
    localparam int CNT_W       = $clog2(MAX_CNT + 1);
    localparam logic [CNT_W-1:0] STOP_LOAD = CNT_W'(STOP_CYCLES - 1);
    localparam logic [CNT_W-1:0] WAIT_LOAD = CNT_W'(RECHECK_CYCLES - 1);

    // R10: the gated window must fit the 2 us budget
    generate
        if (STOP_CYCLES > STOP_BUDGET || STOP_CYCLES < 1) begin : g_bad_stop
            $error("STOP_CYCLES outside 1..2us of clock");
        end
        if (RECHECK_CYCLES < 1) begin : g_bad_wait
            $error("RECHECK_CYCLES must be at least 1");
        end
    endgenerate

    typedef struct packed {
        thr_state_e         state;
        logic [RATIO_W-1:0] ratio;
        logic               dir_up;
        logic               hot;
    } thr_regs_t;

    thr_regs_t d, q;

    logic               trip;
    logic               tmr_load;
    logic [CNT_W-1:0]   tmr_val;
    logic               tmr_done;
    logic [RATIO_W-1:0] r_dn, r_up;
    logic               can_dn, can_up;

    assign trip = (temp_margin == '0);

    thr_ratio_stepper #(.RATIO_W(RATIO_W)) u_step (
        .cur    (q.ratio),
        .lo     (ratio_min),
        .hi     (ratio_max),
        .dn     (r_dn),
        .up     (r_up),
        .can_dn (can_dn),
        .can_up (can_up)
    );

    thr_cycle_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    always_comb begin
        d        = q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        d.hot    = trip & hot_bidir_en;

        unique case (q.state)
            ST_IDLE: begin
                d.ratio = ratio_max;
                if (trip) begin
                    if (can_dn) begin
                        d.state  = ST_STOP;
                        d.ratio  = r_dn;
                        d.dir_up = 1'b0;
                        tmr_load = 1'b1;
                        tmr_val  = STOP_LOAD;
                    end else begin
                        d.state = ST_MOD;
                    end
                end
            end
            ST_STOP: begin
                if (tmr_done) begin
                    if (q.dir_up) begin
                        d.state  = ST_WAIT;
                        tmr_load = 1'b1;
                        tmr_val  = WAIT_LOAD;
                    end else begin
                        d.state = ST_VREQ;
                    end
                end
            end
            ST_VREQ: begin
                if (vr_settled) begin
                    d.state  = ST_WAIT;
                    tmr_load = 1'b1;
                    tmr_val  = WAIT_LOAD;
                end
            end
            ST_WAIT: begin
                if (tmr_done) begin
                    if (trip) begin
                        if (can_dn) begin
                            d.state  = ST_STOP;
                            d.ratio  = r_dn;
                            d.dir_up = 1'b0;
                            tmr_load = 1'b1;
                            tmr_val  = STOP_LOAD;
                        end else begin
                            d.state = ST_MOD;
                        end
                    end else if (can_up) begin
                        d.state  = ST_STOP;
                        d.ratio  = r_up;
                        d.dir_up = 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = STOP_LOAD;
                    end else begin
                        d.state = ST_IDLE;
                    end
                end
            end
            ST_MOD: begin
                if (!trip) begin
                    d.state  = ST_WAIT;
                    tmr_load = 1'b1;
                    tmr_val  = WAIT_LOAD;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.state  <= ST_IDLE;
            q.ratio  <= ratio_max;
            q.dir_up <= 1'b0;
            q.hot    <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign core_clk_en = (q.state != ST_STOP);
    assign vr_down_req = (q.state == ST_VREQ);
    assign clk_mod_en  = (q.state == ST_MOD);
    assign hot_out     = q.hot;
    assign cur_ratio   = q.ratio;
endmodule

// File: rtl/thr_throttle_checker.sv
module thr_throttle_checker #(
    parameter int RATIO_W     = 6,
    parameter int MARGIN_W    = 8,
    parameter int STOP_CYCLES = 400
) (
    input logic                clk,
    input logic                rst_n,
    input logic [MARGIN_W-1:0] temp_margin,
    input logic [RATIO_W-1:0]  ratio_min,
    input logic                hot_bidir_en,
    input logic                core_clk_en,
    input logic [RATIO_W-1:0]  cur_ratio,
    input logic                vr_down_req,
    input logic                hot_out,
    input logic                clk_mod_en
);
    int unsigned low_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= 0;
        end else if (core_clk_en) begin
            low_cnt <= 0;
        end else begin
            low_cnt <= low_cnt + 1;
        end
    end

    p_stop_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !core_clk_en |-> low_cnt < STOP_CYCLES);

    p_stop_exact_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_clk_en) |-> low_cnt == STOP_CYCLES);

    p_ratio_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_ratio != $past(cur_ratio)) |-> !core_clk_en);

    p_ratio_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_ratio != $past(cur_ratio)) |->
            (({1'b0, cur_ratio} + 1'b1 == {1'b0, $past(cur_ratio)}) ||
             ({1'b0, cur_ratio} == {1'b0, $past(cur_ratio)} + 1'b1)));

    p_vreq_running_r5: assert property (@(posedge clk) disable iff (!rst_n)
        vr_down_req |-> core_clk_en && !clk_mod_en);

    p_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cur_ratio >= ratio_min);

    p_mod_at_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clk_mod_en |-> (cur_ratio == ratio_min) && core_clk_en);

    p_hot_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hot_out |-> $past(hot_bidir_en) && ($past(temp_margin) == '0));
endmodule

bind thr_throttle_ctrl thr_throttle_checker #(
    .RATIO_W     (RATIO_W),
    .MARGIN_W    (MARGIN_W),
    .STOP_CYCLES (STOP_CYCLES)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .temp_margin  (temp_margin),
    .ratio_min    (ratio_min),
    .hot_bidir_en (hot_bidir_en),
    .core_clk_en  (core_clk_en),
    .cur_ratio    (cur_ratio),
    .vr_down_req  (vr_down_req),
    .hot_out      (hot_out),
    .clk_mod_en   (clk_mod_en)
);

// File: tb/thr_throttle_ctrl_bench.sv
`timescale 1ns/1ps
module thr_throttle_ctrl_bench;
    localparam int RW   = 6;
    localparam int MW   = 8;
    localparam int MHZ  = 200;
    localparam int S    = 4;
    localparam int RC   = 16;
    localparam int RMAX = 10;
    localparam int RMIN = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [MW-1:0] temp_margin = 8'd20;
    logic [RW-1:0] ratio_min = RW'(RMIN);
    logic [RW-1:0] ratio_max = RW'(RMAX);
    logic          hot_bidir_en = 1'b1;
    logic          manual_settled = 1'b0;
    logic          auto_en = 1'b0;
    logic          auto_resp = 1'b0;
    logic          vr_settled;
    logic          core_clk_en;
    logic [RW-1:0] cur_ratio;
    logic          vr_down_req;
    logic          hot_out;
    logic          clk_mod_en;

    int checks = 0;
    int errors = 0;

    assign vr_settled = manual_settled | auto_resp;

    always #2.5 clk = ~clk;

    always @(negedge clk) begin
        auto_resp <= auto_en && vr_down_req && !auto_resp;
    end

    thr_throttle_ctrl #(
        .RATIO_W(RW), .MARGIN_W(MW), .CLK_MHZ(MHZ),
        .STOP_CYCLES(S), .RECHECK_CYCLES(RC)
    ) u_thr_throttle_ctrl (
        .clk(clk), .rst_n(rst_n), .temp_margin(temp_margin),
        .ratio_min(ratio_min), .ratio_max(ratio_max),
        .hot_bidir_en(hot_bidir_en), .vr_settled(vr_settled),
        .core_clk_en(core_clk_en), .cur_ratio(cur_ratio),
        .vr_down_req(vr_down_req), .hot_out(hot_out), .clk_mod_en(clk_mod_en)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_ratio(input int target);
        for (int i = 0; i < 3000; i++) begin
            if (cur_ratio == RW'(target) && core_clk_en) break;
            @(negedge clk);
        end
        repeat (2 * (RC + S) + 4) @(negedge clk);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk("R1 ratio in reset", cur_ratio, RMAX);
        chk("R1 clk_en in reset", core_clk_en, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ratio after reset", cur_ratio, RMAX);
        chk("R1 clk_en after reset", core_clk_en, 1);
        chk("R1 vr_req after reset", vr_down_req, 0);
        chk("R1 mod after reset", clk_mod_en, 0);
        chk("R1 hot after reset", hot_out, 0);
    endtask

    task automatic t_no_trip;
        int lows = 0;
        int moved = 0;
        for (int i = 0; i < 40; i++) begin
            temp_margin = MW'(1 + (i % 7));
            @(negedge clk);
            if (!core_clk_en) lows++;
            if (cur_ratio != RW'(RMAX)) moved++;
        end
        temp_margin = 8'd20;
        chk("R2 no gating without trip", lows, 0);
        chk("R2 ratio unchanged without trip", moved, 0);
    endtask

    task automatic t_step_sequence;
        int lows = 1;
        int runs = 1;
        int gap = 0;
        int vr_ok = 1;
        temp_margin = '0;
        @(negedge clk);
        chk("R2 step starts on zero margin", core_clk_en, 0);
        chk("R4 ratio lowered by one", cur_ratio, RMAX - 1);
        chk("R3 hot asserted", hot_out, 1);
        while (!core_clk_en && lows < 100) begin
            @(negedge clk);
            if (!core_clk_en) lows++;
        end
        chk("R4 gated window length", lows, S);
        chk("R10 window within 2us", (lows <= 2 * MHZ) ? 1 : 0, 1);
        chk("R5 request after restart", vr_down_req, 1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (!vr_down_req || !core_clk_en) vr_ok = 0;
        end
        chk("R5 request held until settled", vr_ok, 1);
        manual_settled = 1'b1;
        @(negedge clk);
        manual_settled = 1'b0;
        chk("R5 request dropped after settle", vr_down_req, 0);
        while (core_clk_en && runs < 200) begin
            @(negedge clk);
            if (core_clk_en) runs++;
        end
        chk("R6 recheck interval", runs, RC);
        chk("R6 second step ratio", cur_ratio, RMAX - 2);
        temp_margin = 8'd5;
        @(negedge clk);
        chk("R3 hot cleared on cool", hot_out, 0);
        auto_en = 1'b1;
        for (int i = 0; i < 2000; i++) begin
            if (cur_ratio == RW'(RMAX - 1)) break;
            @(negedge clk);
        end
        for (int i = 0; i < 2000; i++) begin
            if (vr_down_req) vr_ok = 0;
            if (cur_ratio == RW'(RMAX)) break;
            @(negedge clk);
            gap++;
        end
        chk("R9 spacing of rises", gap, S + RC);
        chk("R9 no voltage request on rise", vr_ok, 1);
        wait_ratio(RMAX);
        chk("R9 restored to max", cur_ratio, RMAX);
        chk("R9 clock running when idle", core_clk_en, 1);
    endtask

    task automatic t_walk_to_min;
        int lowest = RMAX;
        int mod_ok = 1;
        temp_margin = '0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (int'(cur_ratio) < lowest) lowest = int'(cur_ratio);
            if (clk_mod_en) break;
        end
        chk("R8 modulation reached", clk_mod_en, 1);
        chk("R8 ratio at floor", cur_ratio, RMIN);
        chk("R7 never below floor", lowest, RMIN);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!clk_mod_en || cur_ratio != RW'(RMIN) || !core_clk_en) mod_ok = 0;
        end
        chk("R8 modulation held at floor", mod_ok, 1);
        temp_margin = 8'd3;
        @(negedge clk);
        chk("R8 modulation cleared", clk_mod_en, 0);
        chk("R3 hot cleared after floor", hot_out, 0);
        wait_ratio(RMAX);
        chk("R9 restored from floor", cur_ratio, RMAX);
    endtask

    task automatic t_hot_disabled;
        int hot_seen = 0;
        hot_bidir_en = 1'b0;
        temp_margin = '0;
        @(negedge clk);
        chk("R2 step with hot disabled", cur_ratio, RMAX - 1);
        for (int i = 0; i < 10; i++) begin
            if (hot_out) hot_seen++;
            @(negedge clk);
        end
        chk("R3 hot stays low when not bidirectional", hot_seen, 0);
        temp_margin = 8'd9;
        hot_bidir_en = 1'b1;
        wait_ratio(RMAX);
        chk("R9 restored after hot-disabled run", cur_ratio, RMAX);
    endtask

    task automatic t_floor_equals_max;
        int lows = 0;
        ratio_min = RW'(RMAX);
        @(negedge clk);
        temp_margin = '0;
        @(negedge clk);
        chk("R8 modulation at once when floor is max", clk_mod_en, 1);
        chk("R7 ratio kept at floor", cur_ratio, RMAX);
        for (int i = 0; i < 10; i++) begin
            if (!core_clk_en) lows++;
            @(negedge clk);
        end
        chk("R4 no gating when no step possible", lows, 0);
        temp_margin = 8'd4;
        @(negedge clk);
        chk("R8 modulation off after cool", clk_mod_en, 0);
        repeat (RC + 4) @(negedge clk);
        chk("R9 stays at max", cur_ratio, RMAX);
        ratio_min = RW'(RMIN);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_no_trip();
        t_step_sequence();
        t_walk_to_min();
        t_hot_disabled();
        t_floor_equals_max();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule